// File: doc/BRIEF.md
# One-Pulse Prescaled Delay Timer

This block is an up-counting timer with a small write/read register port. It is built for busy-wait delays. Software first stores a clock divider value and a terminal count in holding registers. It then forces an update so that both values become active at once and both counters restart from zero. Finally it sets the run bit with single-shot mode selected. The counter steps once per divided tick. When it reaches the terminal count it wraps to zero and raises an update flag. In single-shot mode it also clears the run bit itself, and software polls that bit to learn that the delay is over.

Divider and terminal values written by software stay in the holding registers until an update event. An update event is either a wrap or a forced update. A control bit can stop forced updates from raising the flag, so that only a real wrap sets it. A terminal count of zero behaves as one, so a single-shot run always ends.

Top module: `pulse_delay_timer`

## Requirements
- R1: After reset every register reads zero, the run bit is clear and `upd_flag` is low.
- R2: A write to the divider holding register (address 4, bits [15:0]) or the terminal holding register (address 5) does not change the values in use. The held values take effect at the next wrap or forced update.
- R3: Writing 1 to bit 0 of the event register (address 2) copies both holding registers into the active registers and zeroes the divider counter and the main counter in that cycle. The event register always reads 0.
- R4: A forced update sets the flag when the quiet bit (control bit 2) is 0, and leaves the flag unchanged when the quiet bit is 1. A wrap sets the flag whatever the quiet bit holds.
- R5: The flag (status address 1, bit 0, also driven on `upd_flag`) is set by a wrap. A status write with bit 0 equal to 0 clears it, and a status write with bit 0 equal to 1 has no effect. If a wrap and a clearing write fall in the same cycle, the flag ends up set.
- R6: With run (control bit 0) and single-shot (control bit 1) set, the run bit clears exactly (T+1)×(D+1) clocks after the write that set it. T is the active terminal count and D is the active divider. After that the counter reads 0.
- R7: An active terminal count of 0 is treated as 1, so a single-shot run lasts 2×(D+1) clocks.
- R8: With single-shot clear, the counter (address 3) steps 0,1,…,T,0,… and the run bit stays set.
- R9: The counter register is read-only; writes to address 3 do not change it.
- R10: While the run bit is clear and no forced update occurs, the counter holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address: 0 control, 1 status, 2 event, 3 counter, 4 divider, 5 terminal |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| upd_flag | output | 1 | Update flag |

## Verification
Two things can land on the flag in the same clock: a counter wrap that sets it, and a software status write that clears it. The bench starts a single-shot run with divider 0 and terminal 3, so the wrap falls on the fourth edge after the run write. It places the clearing write on exactly that edge. The run passes only if the flag reads set afterwards, and a later clearing write on its own must then drop it.

// File: rtl/pulse_delay_timer.sv
module pulse_delay_timer #(
  parameter int CNT_W = 32,
  parameter int DIV_W = 16,
  parameter int AW    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_we,
  input  logic [AW-1:0]    bus_addr,
  input  logic [CNT_W-1:0] bus_wdata,
  output logic [CNT_W-1:0] bus_rdata,
  output logic             upd_flag
);
  localparam logic [AW-1:0] A_CTRL = AW'(0);
  localparam logic [AW-1:0] A_STAT = AW'(1);
  localparam logic [AW-1:0] A_EVT  = AW'(2);
  localparam logic [AW-1:0] A_CNT  = AW'(3);
  localparam logic [AW-1:0] A_DIV  = AW'(4);
  localparam logic [AW-1:0] A_TOP  = AW'(5);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic             run, single, quiet, flag;
  logic [DIV_W-1:0] div_pre, div_act, div_cnt;
  logic [CNT_W-1:0] top_pre, top_act, top_eff, cnt;
  logic             wr_ctrl, wr_stat, wr_evt, wr_div, wr_top;
  logic             sw_upd, tick, ovf, load, flag_set;

  assign wr_ctrl = bus_we && (bus_addr == A_CTRL);
  assign wr_stat = bus_we && (bus_addr == A_STAT);
  assign wr_evt  = bus_we && (bus_addr == A_EVT);
  assign wr_div  = bus_we && (bus_addr == A_DIV);
  assign wr_top  = bus_we && (bus_addr == A_TOP);

  assign top_eff  = (top_act == '0) ? ONE : top_act;
  assign sw_upd   = wr_evt && bus_wdata[0];
  assign tick     = run && (div_cnt == div_act);
  assign ovf      = tick && (cnt == top_eff);
  assign load     = ovf || sw_upd;
  assign flag_set = ovf || (sw_upd && !quiet);
  assign upd_flag = flag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_cnt <= '0;
      cnt     <= '0;
    end else if (sw_upd) begin
      div_cnt <= '0;
      cnt     <= '0;
    end else if (tick) begin
      div_cnt <= '0;
      cnt     <= ovf ? '0 : cnt + ONE;
    end else if (run) begin
      div_cnt <= div_cnt + DIV_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_pre <= '0;
      top_pre <= '0;
    end else begin
      if (wr_div) div_pre <= bus_wdata[DIV_W-1:0];
      if (wr_top) top_pre <= bus_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_act <= '0;
      top_act <= '0;
    end else if (load) begin
      div_act <= div_pre;
      top_act <= top_pre;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run    <= 1'b0;
      single <= 1'b0;
      quiet  <= 1'b0;
    end else if (wr_ctrl) begin
      run    <= bus_wdata[0];
      single <= bus_wdata[1];
      quiet  <= bus_wdata[2];
    end else if (ovf && single) begin
      run    <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       flag <= 1'b0;
    else if (flag_set)                flag <= 1'b1;
    else if (wr_stat && !bus_wdata[0]) flag <= 1'b0;
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CTRL:  bus_rdata[2:0] = {quiet, single, run};
      A_STAT:  bus_rdata[0]   = flag;
      A_CNT:   bus_rdata      = cnt;
      A_DIV:   bus_rdata[DIV_W-1:0] = div_pre;
      A_TOP:   bus_rdata      = top_pre;
      default: bus_rdata      = '0;
    endcase
  end
endmodule

// File: rtl/pulse_delay_timer_chk.sv
module pulse_delay_timer_chk #(
  parameter int CNT_W = 32,
  parameter int AW    = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_we,
  input logic [AW-1:0]    bus_addr,
  input logic [CNT_W-1:0] bus_wdata,
  input logic             run,
  input logic             single,
  input logic             quiet,
  input logic             flag,
  input logic             ovf,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] top_act
);
  logic force_wr, ctrl_wr, clr_wr;
  assign force_wr = bus_we && (bus_addr == AW'(2)) && bus_wdata[0];
  assign ctrl_wr  = bus_we && (bus_addr == AW'(0));
  assign clr_wr   = bus_we && (bus_addr == AW'(1)) && !bus_wdata[0];

  p_flag_on_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> flag);

  p_clear_wins_alone_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && !ovf) |=> !flag);

  p_single_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && single && !ctrl_wr) |=> !run);

  p_quiet_force_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (force_wr && quiet && !ovf && !flag) |=> !flag);

  p_force_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    force_wr |=> (cnt == '0));

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !force_wr) |=> $stable(cnt));

  p_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt <= ((top_act == '0) ? CNT_W'(1) : top_act)));
endmodule

bind pulse_delay_timer pulse_delay_timer_chk #(.CNT_W(CNT_W), .AW(AW)) chk (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .run(run), .single(single), .quiet(quiet),
  .flag(flag), .ovf(ovf), .cnt(cnt), .top_act(top_act)
);

// File: tb/pulse_delay_timer_test.sv
module pulse_delay_timer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        upd_flag;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          ended = 0;

  always #5 clk = ~clk;

  pulse_delay_timer uut (.clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .upd_flag(upd_flag));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic measure(output int n);
    logic [31:0] v;
    n = 0;
    rd(3'd0, v);
    while (v[0] && n < 2000) begin
      @(negedge clk);
      n++;
      rd(3'd0, v);
    end
  endtask

  task automatic setup(input int div, input int top, input logic [31:0] ctrl);
    wr(3'd0, 32'd4);
    wr(3'd4, div);
    wr(3'd5, top);
    wr(3'd2, 32'd1);
    wr(3'd1, 32'd0);
    wr(3'd0, ctrl);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), v);
      check("R1 reg", v, 0);
    end
    check("R1 flag pin", {31'd0, upd_flag}, 0);
  endtask

  task automatic t_force;
    logic [31:0] v;
    wr(3'd4, 32'd2);
    wr(3'd5, 32'd5);
    wr(3'd2, 32'd1);
    check("R4 force sets flag", {31'd0, upd_flag}, 1);
    rd(3'd2, v);
    check("R3 event reads 0", v, 0);
    wr(3'd1, 32'd1);
    rd(3'd1, v);
    check("R5 write 1 no effect", v, 1);
    wr(3'd1, 32'd0);
    rd(3'd1, v);
    check("R5 write 0 clears", v, 0);
    wr(3'd0, 32'd4);
    wr(3'd2, 32'd1);
    check("R4 quiet force no flag", {31'd0, upd_flag}, 0);
  endtask

  task automatic t_oneshot;
    int n;
    logic [31:0] v;
    wr(3'd0, 32'd7);
    measure(n);
    check("R6 delay (5+1)*(2+1)", n, 18);
    rd(3'd3, v);
    check("R6 counter zero after stop", v, 0);
    check("R4 wrap sets flag with quiet", {31'd0, upd_flag}, 1);
  endtask

  task automatic t_preload;
    int n;
    setup(0, 3, 32'd4);
    wr(3'd5, 32'd9);
    wr(3'd0, 32'd7);
    measure(n);
    check("R2 old terminal in use", n, 4);
    wr(3'd0, 32'd7);
    measure(n);
    check("R2 held terminal after wrap", n, 10);
  endtask

  task automatic t_zero;
    int n;
    setup(1, 0, 32'd4);
    wr(3'd0, 32'd7);
    measure(n);
    check("R7 zero terminal as one", n, 4);
  endtask

  task automatic t_cont;
    logic [31:0] v;
    setup(0, 3, 32'd4);
    wr(3'd0, 32'd5);
    for (int k = 0; k < 10; k++) begin
      rd(3'd3, v);
      check("R8 free-run count", v, k % 4);
      @(negedge clk);
    end
    rd(3'd0, v);
    check("R8 run stays set", {31'd0, v[0]}, 1);
  endtask

  task automatic t_freeze;
    logic [31:0] a, b;
    wr(3'd0, 32'd4);
    rd(3'd3, a);
    repeat (5) @(negedge clk);
    rd(3'd3, b);
    check("R10 counter held", b, a);
    wr(3'd3, 32'h55);
    rd(3'd3, b);
    check("R9 counter write ignored", b, a);
  endtask

  task automatic t_race;
    logic [31:0] v;
    setup(0, 3, 32'd4);
    wr(3'd0, 32'd7);
    repeat (3) @(negedge clk);
    wr(3'd1, 32'd0);
    rd(3'd1, v);
    check("R5 wrap beats clear", v, 1);
    wr(3'd1, 32'd0);
    rd(3'd1, v);
    check("R5 later clear", v, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_force();
    t_oneshot();
    t_preload();
    t_zero();
    t_cont();
    t_freeze();
    t_race();
    if (!ended) begin
      ended = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #500000;
    if (!ended) begin
      ended = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got 1 expected 0");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule